// File: doc/BRIEF.md
# Mode-Dependent Four-Bit Port Controller

This block controls four I/O pins through three byte-wide registers on a simple register bus. The three registers are a direction register, a data register and a pull-up control register. A static three-bit operating-mode input decides what each pin does.

In the low modes the port is taken over as the low four address outputs of an external bus. In mode 5 a pin carries its address line only when its direction bit is set. In modes 6 and 7 the port is plain general-purpose I/O, driven from the data register. The block produces the per-pin output values, the output enables and the pull-up enables. Input pin levels pass through a two-flop synchronizer before they can be read back.

Top module: `port4_mode_ctl`

## Requirements
- R1: After reset in modes 5 to 7, all output enables are 0, all pull-up enables are 0 and pin_o is 0. The data and pull-up registers reset to 0.
- R2: In modes 0 to 4 (mode_i holds the mode number), every output enable is 1 and pin_o equals adr_i. Direction writes have no effect and every pull-up enable is 0.
- R3: In mode 5, pin k is enabled as an output exactly when direction bit k is 1. pin_o[k] is then adr_i[k], and it is 0 when the pin is not enabled.
- R4: In modes 6 and 7, pin k is enabled as an output exactly when direction bit k is 1. pin_o[k] is then data bit k, and it is 0 when the pin is not enabled.
- R5: The direction register sits at offset 0x004 and is write-only: a read there returns 0xFF in every mode. In modes 5 to 7 a write updates its bits 3:0, and write bits 7:4 are ignored.
- R6: pull_en_o[k] is 1 only when pull-up bit k is 1, pin k is not an output, and the mode is 5, 6 or 7. The pull-up register is written at offset 0x03F.
- R7: A read at offset 0xFD4 returns 0xF in bits 7:4. In bits 3:0 it returns the data-register bit for each output pin and the synchronized pin level for each input pin. A read at 0x03F returns 0xF in bits 7:4 and the pull-up bits in bits 3:0. A read at any other offset returns 0x00. Data writes go to 0xFD4, bits 3:0.
- R8: A change on pin_i shows up in the read value at 0xFD4 after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Static operating mode |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| adr_i | input | 4 | Low address bits from the bus controller |
| pin_i | input | 4 | Pin input levels |
| pin_o | output | 4 | Pin output values |
| pin_oe_o | output | 4 | Pin output enables |
| pull_en_o | output | 4 | Pin pull-up enables |

## Verification
A wrong direction bit appears on pin_oe_o, pin_o and pull_en_o in the cycle after the write that set it. The direction register cannot be read back, so these outputs are the only place such a fault shows. A wrong data or pull-up bit appears on pin_o, pull_en_o and the register read value one cycle after the write. A synchronizer that is too short or too long moves the change in the data read value by one cycle, and the bench checks that change at the exact edge.

// File: rtl/port4_pkg.sv
package port4_pkg;
  typedef enum logic [1:0] {
    PM_BUS_FIXED = 2'd0,
    PM_BUS_SEL   = 2'd1,
    PM_GPIO      = 2'd2
  } port_mode_e;

  function automatic port_mode_e decode_mode(input logic [2:0] m);
    if (m <= 3'd4)      return PM_BUS_FIXED;
    else if (m == 3'd5) return PM_BUS_SEL;
    else                return PM_GPIO;
  endfunction
endpackage

// File: rtl/port4_ddr_reg.sv
module port4_ddr_reg import port4_pkg::*; #(
  parameter int N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_mode_e        pmode_i,
  input  logic              wr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] ddr_o
);
  logic [N_PINS-1:0] ddr_q;
  logic              wr_ok;

  // fixed-bus modes lock the register
  assign wr_ok = wr_i && (pmode_i != PM_BUS_FIXED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ddr_q <= '0;
    else if (wr_ok) ddr_q <= wdata_i;
  end

  assign ddr_o = (pmode_i == PM_BUS_FIXED) ? '1 : ddr_q;

  AST_DDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok |=> $stable(ddr_q)); // R5
endmodule

// File: rtl/port4_in_sync.sv
module port4_in_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/port4_pin_mux.sv
module port4_pin_mux import port4_pkg::*; #(
  parameter int N_PINS = 4
) (
  input  port_mode_e        pmode_i,
  input  logic [N_PINS-1:0] ddr_i,
  input  logic [N_PINS-1:0] dr_i,
  input  logic [N_PINS-1:0] pcr_i,
  input  logic [N_PINS-1:0] adr_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] oe_o,
  output logic [N_PINS-1:0] pull_o
);
  logic use_dr;
  logic pull_ok;

  assign use_dr  = (pmode_i == PM_GPIO);
  assign pull_ok = (pmode_i != PM_BUS_FIXED);

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    assign oe_o[k]   = ddr_i[k];
    assign pin_o[k]  = ddr_i[k] & (use_dr ? dr_i[k] : adr_i[k]);
    assign pull_o[k] = pull_ok & pcr_i[k] & ~ddr_i[k];
  end
endmodule

// File: rtl/port4_mode_ctl.sv
module port4_mode_ctl import port4_pkg::*; #(
  parameter int N_PINS = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DDR_OFS = 'h004,
  parameter logic [ADDR_W-1:0] DR_OFS  = 'hFD4,
  parameter logic [ADDR_W-1:0] PCR_OFS = 'h03F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] adr_i,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] pull_en_o
);
  localparam int RSV_W = DATA_W - N_PINS;

  port_mode_e        pmode;
  logic              wr_ddr, wr_dr, wr_pcr;
  logic [N_PINS-1:0] ddr_eff, dr_q, pcr_q, pin_sync, dr_view;

  assign pmode  = decode_mode(mode_i);
  assign wr_ddr = bus_sel_i && bus_we_i && (bus_addr_i == DDR_OFS);
  assign wr_dr  = bus_sel_i && bus_we_i && (bus_addr_i == DR_OFS);
  assign wr_pcr = bus_sel_i && bus_we_i && (bus_addr_i == PCR_OFS);

  port4_ddr_reg #(.N_PINS(N_PINS)) ddr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pmode_i(pmode),
    .wr_i   (wr_ddr),
    .wdata_i(bus_wdata_i[N_PINS-1:0]),
    .ddr_o  (ddr_eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q  <= '0;
      pcr_q <= '0;
    end else begin
      if (wr_dr)  dr_q  <= bus_wdata_i[N_PINS-1:0];
      if (wr_pcr) pcr_q <= bus_wdata_i[N_PINS-1:0];
    end
  end

  port4_in_sync #(.WIDTH(N_PINS), .STAGES(2)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  port4_pin_mux #(.N_PINS(N_PINS)) mux_i (
    .pmode_i(pmode),
    .ddr_i  (ddr_eff),
    .dr_i   (dr_q),
    .pcr_i  (pcr_q),
    .adr_i  (adr_i),
    .pin_o  (pin_o),
    .oe_o   (pin_oe_o),
    .pull_o (pull_en_o)
  );

  assign dr_view = (ddr_eff & dr_q) | (~ddr_eff & pin_sync);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == DDR_OFS)      bus_rdata_o = '1;
    else if (bus_addr_i == DR_OFS)  bus_rdata_o = {{RSV_W{1'b1}}, dr_view};
    else if (bus_addr_i == PCR_OFS) bus_rdata_o = {{RSV_W{1'b1}}, pcr_q};
  end

  AST_FIXED_ALL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i <= 3'd4) |-> (pin_oe_o == '1 && pull_en_o == '0 && pin_o == adr_i)); // R2
  AST_GPIO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 3'd6) |-> (((pin_o ^ dr_q) & pin_oe_o) == '0)); // R4
  AST_BUS_SEL_ADR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd5) |-> (((pin_o ^ adr_i) & pin_oe_o) == '0)); // R3
  AST_NO_PULL_ON_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pin_oe_o) == '0); // R6
  AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0); // R3
  AST_DDR_RD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == DDR_OFS) |-> (bus_rdata_o == '1)); // R5
  AST_DR_RSV_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == DR_OFS) |-> (bus_rdata_o[DATA_W-1:N_PINS] == '1)); // R7
endmodule

// File: tb/port4_mode_ctl_tb.sv
module port4_mode_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd7;
  logic       sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] adr = '0, pin_in = '0, pin_out, oe, pull;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  port4_mode_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .adr_i(adr), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(oe), .pull_en_o(pull)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (mode=%0d)", req, act, exp, mode);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; addr = 12'h100;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0; addr = 12'h100;
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    mode = m; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [3:0] ddr_e, dr_v, pcr_v, src;
    bit fixed;
    for (int m = 0; m < 8; m++) begin
      fixed = (m <= 4);
      adr = 4'hA;
      pin_in = 4'h0;
      do_reset(3'(m));
      // R1 / R2 reset state
      check(fixed ? "R2 reset oe" : "R1 reset oe", {4'h0, oe}, fixed ? 8'h0F : 8'h00);
      check(fixed ? "R2 reset pin_o" : "R1 reset pin_o", {4'h0, pin_out}, fixed ? 8'h0A : 8'h00);
      check("R1 reset pull", {4'h0, pull}, 8'h00);
      rd(12'h03F, v); check("R1 reset pcr", v, 8'hF0);
      rd(12'h004, v); check("R5 ddr read", v, 8'hFF);
      for (int d = 0; d < 16; d++) begin
        dr_v  = 4'(d) ^ 4'h5;
        pcr_v = 4'(d) ^ 4'h3;
        pin_in = 4'(d) ^ 4'hC;
        adr    = 4'(d) ^ 4'h9;
        wr(12'h004, {4'h0, 4'(d)});   // upper write bits 0: must be ignored
        wr(12'hFD4, {4'hA, dr_v});
        wr(12'h03F, {4'h5, pcr_v});
        repeat (2) @(posedge clk);
        @(negedge clk);
        ddr_e = fixed ? 4'hF : 4'(d);
        src   = (m >= 6) ? dr_v : adr;
        check(fixed ? "R2 oe" : "R3/R4 oe", {4'h0, oe}, {4'h0, ddr_e});
        check(fixed ? "R2 pin_o" : ((m == 5) ? "R3 pin_o" : "R4 pin_o"),
              {4'h0, pin_out}, {4'h0, ddr_e & src});
        check("R6 pull", {4'h0, pull}, fixed ? 8'h00 : {4'h0, pcr_v & ~ddr_e});
        rd(12'hFD4, v); check("R7 dr read", v, {4'hF, (ddr_e & dr_v) | (~ddr_e & pin_in)});
        rd(12'h03F, v); check("R7 pcr read", v, {4'hF, pcr_v});
        rd(12'h004, v); check("R5 ddr read", v, 8'hFF);
      end
      rd(12'h100, v); check("R7 unmapped read", v, 8'h00);
    end
    // R8 synchronizer latency
    do_reset(3'd6);
    pin_in = 4'h0;
    repeat (3) @(negedge clk);
    pin_in = 4'h5;
    @(negedge clk);
    rd(12'hFD4, v); check("R8 after one edge", v, 8'hF0);
    @(negedge clk);
    rd(12'hFD4, v); check("R8 after two edges", v, 8'hF5);
    pin_in = 4'hA;
    @(negedge clk);
    rd(12'hFD4, v); check("R8 fall one edge", v, 8'hF5);
    @(negedge clk);
    rd(12'hFD4, v); check("R8 fall two edges", v, 8'hFA);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule